// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind an I2C bus front end that has already turned SCL and SDA into single-cycle events: a Start, a Stop, a sampled data bit on each SCL rise, and an SCL fall. After every Start the block shifts in the first byte, most significant bit first. It then decides whether the byte addresses this device. A byte is accepted when its upper seven bits equal the programmable own address, or when it is the general call code and general call is enabled, or whenever the accept-all mode is on.

On acceptance, the byte is copied into a receive holding register and a buffer-full flag rises. An interrupt flag follows on the falling edge of the ninth (acknowledge) clock. The handler reads the held byte to tell a general call (0x00) from a device-specific address. Both flags stay set until their own one-cycle clear strobe.

All pins are plain control and status pins. The incoming events come from bus timing and cannot be stalled, so there is no valid/ready pair and no back-pressure. Consecutive bus events must be at least one clock apart. In particular, the ninth SCL rise must come at least one cycle after the cycle that follows the eighth.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, `rbf` and `irq` are 0 and `rx_byte` is 0x00.
- R2: After a Start, each `bit_vld` shifts `bit_val` in MSB first. No decision is made until the eighth bit. Bit 0 of the byte is the R/W bit and bits [7:1] are the address.
- R3: When bits [7:1] equal `own_addr`, for either R/W value, the byte is copied to `rx_byte` and `rbf` is 1 by the second clock edge after the eighth `bit_vld`.
- R4: The byte 0x00 is a match only when `gc_en` is 1. The byte 0x01 is never a general call match.
- R5: When `accept_all` is 1, every first byte is a match.
- R6: A byte that does not match sets no flag and leaves `rx_byte` unchanged.
- R7: After a match, `irq` becomes 1 on the first `scl_fall` that follows the ninth `bit_vld`. The `scl_fall` of the eighth clock does not set it.
- R8: A Start or Stop in the middle of a byte discards the partial byte and sets no flag. A new Start counts from bit zero again.
- R9: A Start or Stop after a match but before the ninth falling edge cancels the pending `irq`. `rbf` stays set.
- R10: Bit events with no preceding Start, or after the eighth bit of the address byte, have no effect on flags or `rx_byte`.
- R11: `clr_rbf` and `clr_irq` clear their flag on the next edge. A clear wins over a set in the same cycle.
- R12: `rx_byte` keeps the last matched byte until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | Start or repeated Start seen on the bus |
| stop_evt | input | 1 | Stop seen on the bus |
| bit_vld | input | 1 | SCL rising edge; `bit_val` is the sampled SDA |
| bit_val | input | 1 | SDA value sampled on the SCL rise |
| scl_fall | input | 1 | SCL falling edge |
| own_addr | input | 7 | Programmable own 7-bit address |
| gc_en | input | 1 | Accept the general call address |
| accept_all | input | 1 | Treat every address byte as a match |
| clr_rbf | input | 1 | One-cycle clear of the buffer-full flag |
| clr_irq | input | 1 | One-cycle clear of the interrupt flag |
| rx_byte | output | 8 | Last matched address byte |
| rbf | output | 1 | Receive buffer full |
| irq | output | 1 | Address-match interrupt flag |

## Verification
Random address bytes are biased toward the own address with both R/W values, toward 0x00 and 0x01, and toward arbitrary values, while `gc_en` and `accept_all` are randomized. These patterns separate an own-address hit from a general call hit, a disabled general call and a plain miss. Directed sequences interrupt a byte with Start or Stop, send bits without a Start, and cut off a pending interrupt. They also sample `irq` between the eighth fall and the ninth fall, which exposes an interrupt that fires one clock early. Clear strobes are driven in the exact cycle a flag would be set, to show that clear has priority.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  typedef enum logic [1:0] {
    AR_IDLE      = 2'd0,
    AR_WAIT_RISE = 2'd1,
    AR_WAIT_FALL = 2'd2
  } ack_state_e;
endpackage

// File: rtl/ar_shifter.sv
module ar_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            bit_vld,
  input  logic            bit_val,
  output logic [BITS-1:0] byte_q,
  output logic            done
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      byte_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_evt) begin
        cnt    <= '0;
        active <= 1'b1;
      end else if (stop_evt) begin
        cnt    <= '0;
        active <= 1'b0;
      end else if (active && bit_vld) begin
        byte_q <= {byte_q[BITS-2:0], bit_val};
        if (cnt == LAST) begin
          cnt    <= '0;
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_vld) && !$past(start_evt) && !$past(stop_evt));

  // R8
  no_done_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !done);
endmodule

// File: rtl/ar_compare.sv
module ar_compare #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              accept_all,
  output logic              hit
);
  localparam logic [ADDR_W:0] GC_CODE = '0;

  logic own_hit;
  logic gc_hit;

  always_comb begin
    own_hit = (byte_in[ADDR_W:1] == own_addr);
    gc_hit  = gc_en && (byte_in == GC_CODE);
    hit     = accept_all || own_hit || gc_hit;
  end
endmodule

// File: rtl/ar_flags.sv
module ar_flags
  import i2c_ar_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            bit_vld,
  input  logic            scl_fall,
  input  logic            done,
  input  logic            hit,
  input  logic [BITS-1:0] byte_in,
  input  logic            clr_rbf,
  input  logic            clr_irq,
  output logic [BITS-1:0] rx_byte,
  output logic            rbf,
  output logic            irq
);
  ack_state_e st;
  logic       accept;
  logic       bus_evt;

  always_comb begin
    accept  = done && hit;
    bus_evt = start_evt || stop_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= AR_IDLE;
      rx_byte <= '0;
      rbf     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (accept) rx_byte <= byte_in;

      if (clr_rbf)     rbf <= 1'b0;
      else if (accept) rbf <= 1'b1;

      if (clr_irq) irq <= 1'b0;
      else if (st == AR_WAIT_FALL && scl_fall && !bus_evt) irq <= 1'b1;

      if (bus_evt) begin
        st <= AR_IDLE;
      end else begin
        unique case (st)
          AR_IDLE:      if (accept)   st <= AR_WAIT_RISE;
          AR_WAIT_RISE: if (bit_vld)  st <= AR_WAIT_FALL;
          AR_WAIT_FALL: if (scl_fall) st <= AR_IDLE;
          default:                    st <= AR_IDLE;
        endcase
      end
    end
  end

  // R3
  rbf_set_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbf) |-> $past(done) && $past(hit));

  // R7
  irq_on_ninth_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scl_fall) && ($past(st) == AR_WAIT_FALL));

  // R11
  rbf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rbf |=> !rbf);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |=> !irq);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rx_byte));
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              scl_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              accept_all,
  input  logic              clr_rbf,
  input  logic              clr_irq,
  output logic [ADDR_W:0]   rx_byte,
  output logic              rbf,
  output logic              irq
);
  localparam int BITS = ADDR_W + 1;

  logic [BITS-1:0] sh_byte;
  logic            sh_done;
  logic            addr_hit;

  ar_shifter #(.BITS(BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .byte_q    (sh_byte),
    .done      (sh_done)
  );

  ar_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_in    (sh_byte),
    .own_addr   (own_addr),
    .gc_en      (gc_en),
    .accept_all (accept_all),
    .hit        (addr_hit)
  );

  ar_flags #(.BITS(BITS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .bit_vld   (bit_vld),
    .scl_fall  (scl_fall),
    .done      (sh_done),
    .hit       (addr_hit),
    .byte_in   (sh_byte),
    .clr_rbf   (clr_rbf),
    .clr_irq   (clr_irq),
    .rx_byte   (rx_byte),
    .rbf       (rbf),
    .irq       (irq)
  );

  // R5
  accept_all_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && accept_all && !clr_rbf) |=> rbf);

  // R4
  gc_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && !gc_en && !accept_all && own_addr != '0 && sh_byte == '0)
      |=> $stable(rx_byte));
endmodule

// File: tb/i2c_addr_recognizer_tb_top.sv
module i2c_addr_recognizer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_evt = 0, stop_evt = 0, bit_vld = 0, bit_val = 0, scl_fall = 0;
  logic [6:0] own_addr = 7'h00;
  logic       gc_en = 0, accept_all = 0, clr_rbf = 0, clr_irq = 0;
  logic [7:0] rx_byte;
  logic       rbf, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] exp_rx = 8'h00;

  always #5 clk = ~clk;

  i2c_addr_recognizer dut_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .bit_vld(bit_vld), .bit_val(bit_val), .scl_fall(scl_fall),
    .own_addr(own_addr), .gc_en(gc_en), .accept_all(accept_all),
    .clr_rbf(clr_rbf), .clr_irq(clr_irq),
    .rx_byte(rx_byte), .rbf(rbf), .irq(irq)
  );

  function automatic bit exp_hit(logic [7:0] b, logic [6:0] own, logic gc, logic all);
    return all || (b[7:1] == own) || (gc && b == 8'h00);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1;
    @(negedge clk) start_evt = 0;
    @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1;
    @(negedge clk) stop_evt = 0;
    @(negedge clk);
  endtask

  task automatic rise(logic b);
    @(negedge clk) begin bit_vld = 1; bit_val = b; end
    @(negedge clk) bit_vld = 0;
    @(negedge clk);
  endtask

  task automatic fall();
    @(negedge clk) scl_fall = 1;
    @(negedge clk) scl_fall = 0;
    @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      rise(b[i]);
      fall();
    end
  endtask

  task automatic clear_flags();
    @(negedge clk) begin clr_rbf = 1; clr_irq = 1; end
    @(negedge clk) begin clr_rbf = 0; clr_irq = 0; end
  endtask

  // full address phase: Start, 8 bits, checks, ninth clock, irq check
  task automatic addr_phase(logic [7:0] b, string req);
    bit h;
    h = exp_hit(b, own_addr, gc_en, accept_all);
    clear_flags();
    do_start();
    send_bits(b, 8);
    if (h) exp_rx = b;
    check({req, " rbf after byte"}, {7'd0, rbf}, {7'd0, h});
    check({req, " rx_byte (R12)"}, rx_byte, exp_rx);
    check("R7 irq low after eighth fall", {7'd0, irq}, 8'd0);
    rise(1'b0);
    check("R7 irq low after ninth rise", {7'd0, irq}, 8'd0);
    fall();
    check({req, " R7 irq after ninth fall"}, {7'd0, irq}, {7'd0, h});
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(2);
    // R1 reset state
    check("R1 rbf", {7'd0, rbf}, 8'd0);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 rx_byte", rx_byte, 8'h00);
    rst_n = 1;
    idle(2);

    own_addr = 7'h2A;
    // R10 bits without a Start
    send_bits(8'h54, 8);
    check("R10 no start rbf", {7'd0, rbf}, 8'd0);
    check("R10 no start rx_byte", rx_byte, 8'h00);

    // R3 own address, write and read, R2 MSB-first byte
    addr_phase(8'h54, "R3 own write");
    addr_phase(8'h55, "R2 R3 own read");

    // R6 mismatch
    addr_phase(8'h56, "R6 mismatch");

    // R4 general call disabled / enabled / 0x01
    gc_en = 0; addr_phase(8'h00, "R4 gc disabled");
    gc_en = 1; addr_phase(8'h00, "R4 gc enabled");
    addr_phase(8'h01, "R4 gc read code");
    gc_en = 0;

    // R5 accept-all
    accept_all = 1; addr_phase(8'hC3, "R5 accept all");
    accept_all = 0;

    // R8 Stop mid-byte, then bits with no Start
    clear_flags();
    do_start(); send_bits(8'h54, 3); do_stop(); send_bits(8'h54 << 3, 5);
    check("R8 stop mid-byte rbf", {7'd0, rbf}, 8'd0);
    // R8 Start mid-byte, new byte counted from zero
    do_start(); send_bits(8'hFF, 5); do_start(); send_bits(8'h54, 8);
    exp_rx = 8'h54;
    check("R8 restart rbf", {7'd0, rbf}, 8'd1);
    check("R8 restart rx_byte", rx_byte, exp_rx);
    do_stop();

    // R9 Stop between match and ninth fall
    clear_flags();
    do_start(); send_bits(8'h55, 8); exp_rx = 8'h55;
    rise(1'b0); do_stop(); fall();
    check("R9 irq cancelled", {7'd0, irq}, 8'd0);
    check("R9 rbf kept", {7'd0, rbf}, 8'd1);

    // R10 bits after the address byte are ignored
    clear_flags();
    do_start(); send_bits(8'h54, 8); exp_rx = 8'h54;
    rise(1'b0); fall();
    clear_flags();
    send_bits(8'h55, 8); rise(1'b0); fall();
    check("R10 data bits rbf", {7'd0, rbf}, 8'd0);
    check("R10 data bits irq", {7'd0, irq}, 8'd0);
    check("R10 data bits rx_byte", rx_byte, exp_rx);
    do_stop();

    // R11 clear wins over rbf set
    clear_flags();
    do_start(); send_bits(8'h54, 7);
    @(negedge clk) begin bit_vld = 1; bit_val = 1'b0; end
    @(negedge clk) begin bit_vld = 0; clr_rbf = 1; end
    @(negedge clk) clr_rbf = 0;
    idle(1);
    check("R11 rbf clear wins", {7'd0, rbf}, 8'd0);
    fall(); rise(1'b0);
    // R11 clear wins over irq set
    @(negedge clk) begin scl_fall = 1; clr_irq = 1; end
    @(negedge clk) begin scl_fall = 0; clr_irq = 0; end
    idle(1);
    check("R11 irq clear wins", {7'd0, irq}, 8'd0);
    do_stop();

    // random address phases
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      int sel;
      own_addr   = 7'($urandom);
      gc_en      = 1'($urandom);
      accept_all = ($urandom % 5) == 0;
      sel = $urandom % 4;
      case (sel)
        0: b = {own_addr, 1'($urandom)};
        1: b = {7'd0, 1'($urandom)};
        default: b = 8'($urandom);
      endcase
      addr_phase(b, "R3 R4 R5 R6 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule